// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands and returns the exact double-width product. The default operands are 16 bits wide, and the product is 32 bits wide. The multiplier is built as a tree of levels that repeat the same pattern. The smallest piece is a 2x2-bit cell. In that cell the least significant bit, the crosswise middle bit and the most significant pair are each formed from their own bit products. Above the cell, every level of width W cuts both operands into a high half and a low half. It multiplies the four half pairs in W/2-bit sub-multipliers and adds the results together at the correct offsets. A 16-bit multiplier therefore contains four 8-bit multipliers. Each of those contains four 4-bit multipliers, and each of those contains four 2-bit cells.

A parameter adds one register stage at the output. With that stage present, the block accepts a pair of operands together with `in_valid`. On the next clock edge it presents the product and raises `out_valid`. The product register keeps its value on cycles without a valid input. Without the stage, the product follows the operands combinationally and `out_valid` equals `in_valid`.

Top module: `vcm_mult`

## Requirements
- R1: For any unsigned operands of WIDTH bits (default 16), the product equals the exact integer product of `op_a` and `op_b`, with 2*WIDTH bits and no truncation.
- R2: In the 2x2 base cell, product bit 0 equals the AND of the two operand bit 0 values.
- R3: In the 2x2 base cell, product bit 1 equals the single-bit sum (XOR) of the two crosswise terms a[1]&b[0] and a[0]&b[1].
- R4: In the 2x2 base cell, product bits 3:2 equal a[1]&b[1] plus the carry of the crosswise sum.
- R5: With OUT_REG=1, `out_prod` holds the product of the operands presented with `in_valid`=1 on the previous rising edge, and `out_valid` equals the value `in_valid` had at the previous rising edge.
- R6: With OUT_REG=1, a cycle with `in_valid`=0 leaves `out_prod` unchanged.
- R7: While `rst` is high at a rising edge, `out_valid` and `out_prod` are cleared to 0 at that edge.
- R8: The corner operands give exact results: 0 times anything is 0, 1 times x is x, and 0xFFFF times 0xFFFF is 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | `out_prod` holds a fresh product |
| out_prod | output | 2*WIDTH | Unsigned product |

## Verification
Each part of the test looks at a different way the multiplier can go wrong:

- **Base cell.** All 16 operand pairs are applied to the 2x2 cell on its own. This separates a wrong least significant term, a wrong crosswise sum and a lost crosswise carry.
- **Corner operands.** At the top level, zero, one and all-ones operands check that no partial product is dropped and that the final carry reaches bit 31.
- **Walking ones.** A single set bit in each operand places its product in each quadrant of every level in turn, so a partial product added at the wrong shift shows up as a wrong bit position.
- **Random operands with gaps in `in_valid`.** These cover carries between the level sums. They also show whether the output register captures only on valid cycles and keeps its value otherwise.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // Number of recursion levels above the 2x2 cell for a given width.
  function automatic int vcm_depth(input int w);
    int d;
    int v;
    d = 0;
    v = w;
    while (v > 2) begin
      v = v / 2;
      d = d + 1;
    end
    return d;
  endfunction

  // True when the width is a power of two of at least 2.
  function automatic bit vcm_width_ok(input int w);
    int v;
    v = w;
    if (v < 2) return 1'b0;
    while (v > 2) begin
      if ((v % 2) != 0) return 1'b0;
      v = v / 2;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic       lsb_term;
  logic       cross_lo;
  logic       cross_hi;
  logic       mid_bit;
  logic       mid_carry;
  logic       msb_term;
  logic [1:0] top_pair;

  // vertical on the right: bit 0
  assign lsb_term  = a[0] & b[0];
  // crosswise terms: bit 1 plus carry
  assign cross_lo  = a[1] & b[0];
  assign cross_hi  = a[0] & b[1];
  assign mid_bit   = cross_lo ^ cross_hi;
  assign mid_carry = cross_lo & cross_hi;
  // vertical on the left plus carry: bits 3:2
  assign msb_term  = a[1] & b[1];
  assign top_pair  = {1'b0, msb_term} + {1'b0, mid_carry};

  assign p = {top_pair, mid_bit, lsb_term};

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_CELL_EXACT: assert (p == ({2'b00, a} * {2'b00, b})); // R2
    end
  end

endmodule

// File: rtl/vcm_level.sv
module vcm_level #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (W == 2) begin : g_leaf
      vcm_cell2 cell_i (
        .a(a),
        .b(b),
        .p(p)
      );
    end else begin : g_split
      logic [H-1:0]   a_hi, a_lo, b_hi, b_lo;
      logic [W-1:0]   pp_hh, pp_hl, pp_lh, pp_ll;
      logic [W:0]     cross_sum;
      logic [2*W-1:0] outer_cat;
      logic [2*W-1:0] cross_shift;

      assign a_hi = a[W-1:H];
      assign a_lo = a[H-1:0];
      assign b_hi = b[W-1:H];
      assign b_lo = b[H-1:0];

      vcm_level #(.W(H)) hh_i (.a(a_hi), .b(b_hi), .p(pp_hh));
      vcm_level #(.W(H)) hl_i (.a(a_hi), .b(b_lo), .p(pp_hl));
      vcm_level #(.W(H)) lh_i (.a(a_lo), .b(b_hi), .p(pp_lh));
      vcm_level #(.W(H)) ll_i (.a(a_lo), .b(b_lo), .p(pp_ll));

      // The outer products never overlap, so concatenation replaces an add.
      assign outer_cat   = {pp_hh, pp_ll};
      assign cross_sum   = {1'b0, pp_hl} + {1'b0, pp_lh};
      assign cross_shift = {{(W-H-1){1'b0}}, cross_sum, {H{1'b0}}};
      assign p           = outer_cat + cross_shift;

      always_comb begin
        if (!$isunknown({a, b})) begin
          AST_LEVEL_EXACT: assert (p == ({{W{1'b0}}, a} * {{W{1'b0}}, b})); // R1
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] out_prod
);
  import vcm_pkg::*;

  localparam int PW    = 2 * WIDTH;
  localparam int DEPTH = vcm_depth(WIDTH);

  initial begin
    if (!vcm_width_ok(WIDTH)) $error("vcm_mult: WIDTH must be a power of two >= 2");
  end

  logic [PW-1:0] core_prod;

  vcm_level #(.W(WIDTH)) core_i (
    .a(op_a),
    .b(op_b),
    .p(core_prod)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [PW-1:0] prod_q;
      logic          vld_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          prod_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) prod_q <= core_prod;
        end
      end

      assign out_prod  = prod_q;
      assign out_valid = vld_q;

      AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R5
      AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R5
      AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_prod == ({{WIDTH{1'b0}}, $past(op_a)} * {{WIDTH{1'b0}}, $past(op_b)}))); // R5
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_prod)); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_prod == '0)); // R7
    end else begin : g_comb
      assign out_prod  = core_prod;
      assign out_valid = in_valid;
    end
  endgenerate

  // Depth is informational only; keep it referenced for elaboration checks.
  initial begin
    if (DEPTH < 0) $error("vcm_mult: bad depth");
  end

endmodule

// File: tb/vcm_mult_tb.sv
module vcm_mult_tb_top;
  localparam int WIDTH = 16;
  localparam int PW    = 2 * WIDTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             out_valid;
  logic [PW-1:0]    out_prod;

  logic [1:0] c_a = '0, c_b = '0;
  logic [3:0] c_p;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  vcm_mult #(.WIDTH(WIDTH), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  vcm_cell2 cell_dut_i (.a(c_a), .b(c_b), .p(c_p));

  // Behavioural reference, one register deep.
  logic          m_valid = 1'b0;
  logic [PW-1:0] m_prod  = '0;
  string         m_tag   = "R7";
  string         drive_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_prod  <= '0;
      m_tag   <= "R7";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_prod <= PW'(longint'(op_a) * longint'(op_b));
        m_tag  <= drive_tag;
      end else begin
        m_tag <= "R6";
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on every falling edge once the model is armed.
  always @(negedge clk) begin
    if (model_on && !done) begin
      check("R5", longint'(out_valid), longint'(m_valid));
      check(m_tag, longint'(out_prod), longint'(m_prod));
    end
  end

  task automatic drive(input logic v, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input string tag);
    @(negedge clk);
    #1;
    in_valid  = v;
    op_a      = a;
    op_b      = b;
    drive_tag = tag;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // Exhaustive base cell: R2, R3, R4
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        c_a = 2'(i);
        c_b = 2'(j);
        #1;
        check("R2", longint'(c_p[0]), longint'(i & j & 1));
        check("R3", longint'(c_p[1]), longint'(((i >> 1) & j & 1) ^ (i & (j >> 1) & 1)));
        check("R4", longint'(c_p[3:2]),
              longint'(((i >> 1) & (j >> 1) & 1) + (((i >> 1) & j & 1) & (i & (j >> 1) & 1))));
        check("R1", longint'(c_p), longint'(i * j));
      end
    end

    // Reset state: R7
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", longint'(out_valid), 0);
    check("R7", longint'(out_prod), 0);
    rst = 1'b0;
    model_on = 1'b1;

    // Corners: R8
    drive(1'b1, 16'h0000, 16'hFFFF, "R8");
    drive(1'b1, 16'h0001, 16'hBEEF, "R8");
    drive(1'b1, 16'hFFFF, 16'h0001, "R8");
    drive(1'b1, 16'hFFFF, 16'hFFFF, "R8");
    drive(1'b0, 16'h1234, 16'h5678, "R6");
    drive(1'b0, 16'hAAAA, 16'h5555, "R6");
    drive(1'b1, 16'h8000, 16'h8000, "R8");
    drive(1'b0, 16'h0000, 16'h0000, "R6");
    @(negedge clk);
    #1;
    check("R8", longint'(out_prod), longint'(32'h4000_0000));

    // Walking ones: R1
    for (int i = 0; i < WIDTH; i++) begin
      drive(1'b1, 16'(1 << i), 16'(1 << ((i * 5) % WIDTH)), "R1");
    end

    // Random with valid gaps: R1, R5, R6
    for (int k = 0; k < 400; k++) begin
      drive(($urandom % 4) != 0, 16'($urandom), 16'($urandom), "R1");
    end

    // Reset mid-stream clears state: R7
    drive(1'b1, 16'hFFFF, 16'hFFFE, "R1");
    @(negedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    check("R7", longint'(out_valid), 0);
    check("R7", longint'(out_prod), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule